// File: doc/BRIEF.md
# Register-Driven SPI Master Controller

This block is a host-programmed SPI master. A host core programs it through a small register bus with single-cycle accesses. The host sets the word size, clock polarity, clock phase and bit-rate divider, and chooses which of several slaves are wired as select outputs. It then moves one word at a time through a transmit buffer and a receive buffer. The controller drives SCK, MOSI and the active-low selects, and samples MISO.

Each word has to be started by the host. A start-mode field in the control register picks the start event. In one mode a write to the transmit buffer starts the word. In the other a read of the receive buffer starts it, so that collecting one result launches the next exchange. When the clock phase is 0 the hardware drives the enabled selects for the length of each word. When the phase is 1 the host drives them directly through level bits.

The register bus is a plain control interface. It has no valid/ready handshake, because every access completes in the cycle it is presented. Read data is combinational from the address. Nothing is queued, so an extra start event while a word is in flight is dropped.

Top module: `spi_host_master`

## Requirements
- R1: After reset the control, baud and select-enable registers are zero, every select level bit is 1, every ss_n output is high, SCK is low, and the busy and full status bits are 0.
- R2: With start mode 2'b01 (CTRL[6:5]), an enabled master (CTRL[0]=1, CTRL[1]=1) that is idle starts a word on the clock edge that takes a write to the transmit buffer, and that word carries the value just written. With start mode 2'b00, a transmit-buffer write only stores the value.
- R3: With start mode 2'b00, an idle enabled master starts a word on the edge that takes a read of the receive buffer, and that word carries the value held in the transmit buffer.
- R4: No word starts when the start mode is 2'b10 or 2'b11, when CTRL[0] or CTRL[1] is 0, or when a word is already in flight. A start event refused in this way leaves busy at 0, or leaves the running word to end on time with no second word after it.
- R5: CTRL[2]=1 selects 16-bit words and CTRL[2]=0 selects 8-bit words. Bits go out on MOSI most significant bit first. MISO bits collected in the same order end up in the receive buffer, and an 8-bit word reads back with its upper byte zero.
- R6: A word lasts 2·bits·E system clocks, where E is the baud register value, or 2 when that value is 0 or 1. Status bit 0 (busy) is 1 from the edge after the start edge up to the edge that ends the word.
- R7: SCK rests at CTRL[3] (polarity) whenever no word is in flight, and it makes exactly 2·bits transitions per word. With CTRL[4]=0 data is sampled on leading edges; with CTRL[4]=1 it is sampled on trailing edges.
- R8: With CTRL[4]=0, every slave whose enable bit is set has ss_n low for the whole word and high while idle.
- R9: With CTRL[4]=1, each enabled slave's ss_n equals its level bit, and each non-enabled ss_n is high.
- R10: Status bit 1 (full) is set on the edge that ends a word. It is cleared by a read of the receive buffer, and an ending word takes priority over a clear in the same cycle.
- R11: The register map is: address 0 control, 1 baud divider, 2 select (enable for slave i at bit i, level at bit 8+i), 3 status (read only), 4 transmit buffer, 5 receive buffer. Written control fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The bench counts edges from the edge that accepts the start event. Busy must still be 1 after 2·bits·E−1 further edges and must read 0 after exactly 2·bits·E. The receive buffer, the full flag and the idle selects are checked in that same cycle, on the falling clock edge. Status and buffer values are due in the cycle of the access, because read data is combinational and register writes take effect on the accepting edge. The bench checks them half a cycle after that edge. MOSI and MISO are checked bit by bit by a slave model that reacts to each SCK transition, so the phase rules are tested at the pins and not through any cycle count.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_BAUD = 3'd1;
  localparam logic [2:0] ADR_SEL  = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_TX   = 3'd4;
  localparam logic [2:0] ADR_RX   = 3'd5;

  localparam logic [1:0] MODE_ON_RX_READ = 2'b00;
  localparam logic [1:0] MODE_ON_TX_WRITE = 2'b01;

  typedef struct packed {
    logic [1:0] start_mode;
    logic       cpha;
    logic       cpol;
    logic       size16;
    logic       master;
    logic       enable;
  } ctrl_t;

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);

  logic [BAUD_W-1:0] eff;
  logic [BAUD_W-1:0] cnt;

  // half period in system clocks, never below two
  assign eff  = (baud < BAUD_W'(2)) ? BAUD_W'(2) : baud;
  assign tick = run && (cnt == eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r6_divider_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < eff));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic          size16,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);

  localparam int SHORT = DW / 2;
  localparam int HW    = $clog2(2 * DW);

  logic [HW-1:0] half;
  logic [HW-1:0] last_half;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] rx_full_word;
  logic          ph;
  logic          sample_now;
  logic          shift_now;

  assign last_half  = size16 ? HW'(2 * DW - 1) : HW'(2 * SHORT - 1);
  // even half-ends are leading SCK edges
  assign sample_now = tick && (cpha ? half[0] : !half[0]);
  assign shift_now  = tick && (cpha ? (!half[0] && half != '0) : half[0]);
  assign done       = busy && tick && (half == last_half);

  assign sck  = cpol ^ ph;
  assign mosi = size16 ? tx_sr[DW-1] : tx_sr[SHORT-1];

  always_comb begin
    rx_full_word = cpha ? {rx_sr[DW-2:0], miso} : rx_sr;
    if (!size16) rx_full_word[DW-1:SHORT] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      half    <= '0;
      ph      <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      half  <= '0;
      ph    <= 1'b0;
      tx_sr <= tx_word;
      rx_sr <= '0;
    end else if (busy && tick) begin
      ph <= ~ph;
      if (sample_now) rx_sr <= {rx_sr[DW-2:0], miso};
      if (shift_now)  tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (done) begin
        busy    <= 1'b0;
        half    <= '0;
        ph      <= 1'b0;
        rx_word <= rx_full_word;
      end else begin
        half <= half + 1'b1;
      end
    end
  end

  a_r6_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (half <= last_half));
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  a_r6_single_finish: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/spi_ssel.sv
module spi_ssel #(
  parameter int NS = 4
) (
  input  logic          cpha,
  input  logic          busy,
  input  logic [NS-1:0] sel_en,
  input  logic [NS-1:0] sel_lvl,
  output logic [NS-1:0] ss_n
);

  for (genvar i = 0; i < NS; i++) begin : g_slave
    always_comb begin
      if (!sel_en[i])  ss_n[i] = 1'b1;
      else if (cpha)   ss_n[i] = sel_lvl[i];
      else             ss_n[i] = !busy;
    end
  end

endmodule

// File: rtl/spi_host_master.sv
module spi_host_master
  import spi_host_pkg::*;
#(
  parameter int NUM_SS = 4,
  parameter int DATA_W = 16,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);

  localparam int LVL_LSB = 8;

  ctrl_t              ctrl;
  logic [BAUD_W-1:0]  baud;
  logic [NUM_SS-1:0]  sel_en;
  logic [NUM_SS-1:0]  sel_lvl;
  logic [DATA_W-1:0]  tx_buf;
  logic [DATA_W-1:0]  rx_word;
  logic               rx_full;
  logic               busy;
  logic               tick;
  logic               done;
  logic               trig_tx;
  logic               trig_rx;
  logic               start;
  logic               rx_read;
  logic [DATA_W-1:0]  sel_view;
  logic [DATA_W-1:0]  tx_word;

  assign rx_read = bus_rd && (bus_addr == ADR_RX);
  assign trig_tx = bus_wr && (bus_addr == ADR_TX) && (ctrl.start_mode == MODE_ON_TX_WRITE);
  assign trig_rx = rx_read && (ctrl.start_mode == MODE_ON_RX_READ);
  assign start   = ctrl.enable && ctrl.master && !busy && (trig_tx || trig_rx);
  assign tx_word = trig_tx ? bus_wdata : tx_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      baud    <= '0;
      sel_en  <= '0;
      sel_lvl <= '1;
      tx_buf  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_CTRL: ctrl   <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
        ADR_BAUD: baud   <= bus_wdata[BAUD_W-1:0];
        ADR_SEL: begin
          sel_en  <= bus_wdata[NUM_SS-1:0];
          sel_lvl <= bus_wdata[LVL_LSB +: NUM_SS];
        end
        ADR_TX:   tx_buf <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_full <= 1'b0;
    else if (done)    rx_full <= 1'b1;
    else if (rx_read) rx_full <= 1'b0;
  end

  always_comb begin
    sel_view = '0;
    sel_view[NUM_SS-1:0]         = sel_en;
    sel_view[LVL_LSB +: NUM_SS]  = sel_lvl;
  end

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = DATA_W'(ctrl);
      ADR_BAUD: bus_rdata = DATA_W'(baud);
      ADR_SEL:  bus_rdata = sel_view;
      ADR_STAT: bus_rdata = DATA_W'({rx_full, busy});
      ADR_TX:   bus_rdata = tx_buf;
      ADR_RX:   bus_rdata = rx_word;
      default:  bus_rdata = '0;
    endcase
  end

  spi_clkgen #(.BAUD_W(BAUD_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .baud (baud),
    .tick (tick)
  );

  spi_shifter #(.DW(DATA_W)) u_shifter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick   (tick),
    .size16 (ctrl.size16),
    .cpol   (ctrl.cpol),
    .cpha   (ctrl.cpha),
    .tx_word(tx_word),
    .miso   (miso),
    .busy   (busy),
    .sck    (sck),
    .mosi   (mosi),
    .done   (done),
    .rx_word(rx_word)
  );

  spi_ssel #(.NS(NUM_SS)) u_ssel (
    .cpha   (ctrl.cpha),
    .busy   (busy),
    .sel_en (sel_en),
    .sel_lvl(sel_lvl),
    .ss_n   (ss_n)
  );

  a_r4_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl.start_mode[1]) |=> !busy);
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(ctrl.enable && ctrl.master)) |=> !busy);
  a_r10_full_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_full);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !done) |=> !rx_full);
  a_r8_auto_select: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl.cpha) |-> ((ss_n & sel_en) == '0));
  a_r9_manual_select: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cpha |-> (ss_n == (sel_lvl | ~sel_en)));

endmodule

// File: tb/sim_spi_host_master.sv
`timescale 1ns/1ps
module sim_spi_host_master;

  localparam int NS = 4;
  localparam logic [2:0] A_CTRL = 3'd0, A_BAUD = 3'd1, A_SEL = 3'd2,
                         A_STAT = 3'd3, A_TX = 3'd4, A_RX = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = 3'd0;
  logic [15:0]   bus_wdata = 16'h0;
  logic [15:0]   bus_rdata;
  logic          sck, mosi;
  logic          miso = 1'b0;
  logic [NS-1:0] ss_n;
  int            checks = 0, errors = 0;
  bit            finished = 0;

  always #2.5 clk = ~clk;

  spi_host_master #(.NUM_SS(NS), .DATA_W(16), .BAUD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // access accepted on the next rising edge; returns 1 ns after it
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic int word_cycles(input bit sz, input logic [15:0] baud);
    int eff = (baud < 16'd2) ? 2 : int'(baud);
    return 2 * (sz ? 16 : 8) * eff;
  endfunction

  task automatic run_word(input bit cpol, input bit cpha, input bit sz,
                          input logic [15:0] baud, input bit m00,
                          input logic [15:0] tx, input logic [15:0] slv,
                          input logic [NS-1:0] en, input logic [NS-1:0] lvl);
    int          bits = sz ? 16 : 8;
    int          n = word_cycles(sz, baud);
    logic [15:0] mask = sz ? 16'hFFFF : 16'h00FF;
    logic [15:0] sr, cap, d;
    logic [NS-1:0] ss_busy = cpha ? (lvl | ~en) : ~en;
    logic [NS-1:0] ss_idle = cpha ? (lvl | ~en) : {NS{1'b1}};
    bus_write(A_SEL, {4'b0, lvl, 4'b0, en});
    bus_write(A_BAUD, baud);
    bus_write(A_CTRL, {9'b0, (m00 ? 2'b00 : 2'b01), cpha, cpol, sz, 1'b1, 1'b1});
    sr = sz ? slv : {slv[7:0], 8'h00};
    miso = sr[15];
    cap = 16'h0;
    fork
      begin
        if (m00) begin
          bus_write(A_TX, tx);
          peek(A_STAT, d); chk("R2", "tx write in mode 00 starts nothing", d[0], 1'b0);
          bus_read(A_RX);
        end else begin
          bus_write(A_TX, tx);
        end
        bus_addr = A_STAT;
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        chk(m00 ? "R3" : "R2", "busy during word", bus_rdata[0], 1'b1);
        chk(cpha ? "R9" : "R8", "select during word", ss_n, ss_busy);
        @(posedge clk); @(negedge clk);
        chk("R6", "busy clear at word end", bus_rdata[0], 1'b0);
        chk("R10", "full at word end", bus_rdata[1], 1'b1);
        chk(cpha ? "R9" : "R8", "select idle", ss_n, ss_idle);
        chk("R7", "sck idle level", sck, cpol);
        peek(A_RX, d); chk("R5", "received word", d, slv & mask);
      end
      begin
        for (int e = 0; e < 2 * bits; e++) begin
          @(sck);
          if ((e % 2 == 0) != cpha) cap = {cap[14:0], mosi};
          else if (!(cpha && e == 0)) begin sr = {sr[14:0], 1'b0}; miso = sr[15]; end
        end
      end
    join
    chk("R5", "mosi bits", cap, tx & mask);
    if (!m00) begin
      bus_read(A_RX);
      peek(A_STAT, d); chk("R10", "rx read clears full", d[1], 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    peek(A_CTRL, d); chk("R1", "ctrl reset", d, 16'h0);
    peek(A_SEL, d);  chk("R1", "select reset", d, 16'h0F00);
    peek(A_STAT, d); chk("R1", "status reset", d, 16'h0);
    chk("R1", "ss_n reset", ss_n, 4'hF);
    chk("R1", "sck reset", sck, 1'b0);

    bus_write(A_CTRL, 16'h005E);
    peek(A_CTRL, d); chk("R11", "ctrl readback", d, 16'h005E);

    // reserved start mode
    bus_write(A_CTRL, 16'h0043);
    bus_write(A_TX, 16'h1234);
    repeat (3) @(posedge clk); @(negedge clk);
    peek(A_STAT, d); chk("R4", "reserved mode no start", d[0], 1'b0);
    chk("R4", "reserved mode sck quiet", sck, 1'b0);

    // master bit clear
    bus_write(A_CTRL, 16'h0021);
    bus_write(A_TX, 16'h00A5);
    @(negedge clk);
    peek(A_STAT, d); chk("R4", "disabled no start", d[0], 1'b0);

    // manual selects with phase 1 while idle
    bus_write(A_SEL, 16'h0507);
    bus_write(A_CTRL, 16'h0031);
    @(negedge clk); chk("R9", "manual select levels", ss_n, 4'b1101);

    // directed words
    run_word(1'b0, 1'b0, 1'b0, 16'd0, 1'b0, 16'hFFA5, 16'h003C, 4'b0001, 4'hF);
    run_word(1'b1, 1'b1, 1'b1, 16'd3, 1'b1, 16'h8001, 16'hC3A5, 4'b1010, 4'b0110);
    run_word(1'b0, 1'b1, 1'b0, 16'd1, 1'b1, 16'h0080, 16'h0001, 4'b0100, 4'b0000);

    // start event while busy is dropped
    bus_write(A_CTRL, 16'h0023);
    bus_write(A_BAUD, 16'd2);
    n = word_cycles(1'b0, 16'd2);
    bus_write(A_TX, 16'h0011);
    bus_write(A_TX, 16'h0022);
    bus_addr = A_STAT;
    repeat (n - 2) @(posedge clk); @(negedge clk);
    chk("R6", "busy before end", bus_rdata[0], 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R4", "busy clear, no queued word", bus_rdata[0], 1'b0);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R4", "no second word", bus_rdata[0], 1'b0);

    // full bit: read clears it
    bus_read(A_RX);
    peek(A_STAT, d); chk("R10", "full cleared", d[1], 1'b0);

    // random words
    for (int k = 0; k < 24; k++) begin
      logic [NS-1:0] en = NS'($urandom_range(1, 15));
      run_word(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom_range(0, 5)),
               1'($urandom), 16'($urandom), 16'($urandom), en, NS'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule